// File: doc/BRIEF.md
# Address Translation Operation Unit

This unit accepts writes to a small set of translation-operation codes and turns each supported write into one translation request to an external translator. The written data word is the virtual address. The operation code picks the privilege level and the access direction. The request travels over a valid/ready handshake. The unit then waits for a single response, which carries either a physical page number with attribute bits or a fault status.

The unit formats each response into a 32-bit result register. A successful translation gives the physical page number in the upper bits and the attributes below it, with bit 0 clear. A fault gives the fault-status fields with bit 0 set as the fault flag. While a translation is in flight, the unit reports busy and keeps the previous result visible. A further operation write during that time is dropped and reported as an overrun. Codes that name the other security world are not translated; they are rejected with an error pulse.

Top module: `xlat_result_unit`

## Requirements
- R1: Operation codes 0 (privileged read), 1 (privileged write), 2 (user read) and 3 (user write), written while idle, issue one request. In that request `xreq_mbo_o`=1, `xreq_user_o`=code bit 1, `xreq_write_o`=code bit 0, `xreq_va_o`=the written data and `xreq_size_o`=0, which means one byte.
- R2: Codes 4 to 7 written while idle issue no request and leave `busy_o` low and `par_o` unchanged. `err_o` is high for exactly the one cycle after the write.
- R3: `xreq_valid_o` rises in the cycle after an accepted write and stays high, with all request fields stable, until `xreq_ready_i` is sampled high. It is low from the next cycle.
- R4: On a successful response, `par_o` becomes {`xrsp_ppn_i`, `xrsp_attr_i`, 1'b0}: the page number in bits 31:12, the attributes in bits 11:1, and bit 0 = 0.
- R5: On a fault response, `par_o` holds `xrsp_ext_i` at bit 6, `xrsp_fs_i[4]` at bit 5, `xrsp_fs_i[3:0]` at bits 4:1, bit 0 = 1 and bits 31:7 = 0.
- R6: `busy_o` is high from the cycle after an accepted write until the cycle after `xrsp_valid_i` is sampled once the request has been taken; it is then low.
- R7: `par_o` keeps its previous value while busy. It changes only in the cycle after the response is sampled.
- R8: An operation write while busy is ignored: the request fields and the final result are unaffected. `overrun_o` is high for the one following cycle.
- R9: After reset, `par_o`=0 and `busy_o`, `err_o`, `overrun_o` and `xreq_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_we_i | input | 1 | Operation write strobe |
| op_sel_i | input | 3 | Operation code |
| op_data_i | input | 32 | Write data, used as virtual address |
| par_o | output | 32 | Translation result register |
| busy_o | output | 1 | Translation in flight |
| err_o | output | 1 | Unsupported-code pulse |
| overrun_o | output | 1 | Write-while-busy pulse |
| xreq_valid_o | output | 1 | Request valid |
| xreq_ready_i | input | 1 | Request accepted by translator |
| xreq_va_o | output | 32 | Request virtual address |
| xreq_size_o | output | 2 | Log2 of access bytes, always 0 |
| xreq_mbo_o | output | 1 | Must-be-one request flag |
| xreq_user_o | output | 1 | User-privilege request flag |
| xreq_write_o | output | 1 | Write-access request flag |
| xrsp_valid_i | input | 1 | Response valid |
| xrsp_fault_i | input | 1 | Response is a fault |
| xrsp_ppn_i | input | 20 | Physical page number |
| xrsp_attr_i | input | 11 | Attribute bits |
| xrsp_ext_i | input | 1 | External abort indication |
| xrsp_fs_i | input | 5 | Fault status code |

## Verification
The hardest case to reach is an operation write that arrives while the previous one has already been handed to the translator but not yet answered. The result must stay at its old value, and the overrun must leave no trace in the final result. The bench acts as the translator and controls both the ready delay and the response delay. It inserts a conflicting write, with a different code and a different address, into that waiting window. It then checks that the completed result and the request fields belong to the original operation only. Sweeps over all eight codes and all 64 fault-status and abort combinations cover the decode and both result formats.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } xlat_state_e;

  typedef struct packed {
    logic mbo;
    logic user;
    logic write;
  } xlat_mode_t;
endpackage

// File: rtl/xlat_op_decode.sv
module xlat_op_decode #(
  parameter int OP_W     = 3,
  parameter int N_SUPP   = 4
) (
  input  logic [OP_W-1:0]       op_sel_i,
  output logic                  supported_o,
  output xlat_pkg::xlat_mode_t  mode_o
);
  localparam logic [OP_W-1:0] SUPP_LIM = OP_W'(N_SUPP);

  always_comb begin
    supported_o  = (op_sel_i < SUPP_LIM);
    mode_o.mbo   = 1'b1;
    mode_o.user  = op_sel_i[1];
    mode_o.write = op_sel_i[0];
  end
endmodule

// File: rtl/xlat_req_ctrl.sv
module xlat_req_ctrl #(
  parameter int VA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  op_we_i,
  input  logic                  supported_i,
  input  xlat_pkg::xlat_mode_t  mode_i,
  input  logic [VA_W-1:0]       va_i,
  input  logic                  xreq_ready_i,
  input  logic                  xrsp_valid_i,
  output logic                  xreq_valid_o,
  output logic [VA_W-1:0]       xreq_va_o,
  output xlat_pkg::xlat_mode_t  xreq_mode_o,
  output logic                  busy_o,
  output logic                  err_o,
  output logic                  overrun_o,
  output logic                  rsp_take_o
);
  import xlat_pkg::*;

  xlat_state_e state_q, state_d;
  logic        accept;

  assign accept     = op_we_i && (state_q == ST_IDLE) && supported_i;
  assign rsp_take_o = (state_q == ST_WAIT) && xrsp_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)       state_d = ST_REQ;
      ST_REQ:  if (xreq_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (xrsp_valid_i) state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      xreq_va_o   <= '0;
      xreq_mode_o <= '0;
      err_o       <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      state_q   <= state_d;
      err_o     <= op_we_i && (state_q == ST_IDLE) && !supported_i;
      overrun_o <= op_we_i && (state_q != ST_IDLE);
      if (accept) begin
        xreq_va_o   <= va_i;
        xreq_mode_o <= mode_i;
      end
    end
  end

  assign xreq_valid_o = (state_q == ST_REQ);
  assign busy_o       = (state_q != ST_IDLE);

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xreq_valid_o && !xreq_ready_i |=> xreq_valid_o && $stable(xreq_va_o) && $stable(xreq_mode_o));
  // R8
  overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_we_i && busy_o |=> overrun_o && $stable(xreq_va_o));
  // R2
  unsupported_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_we_i && !busy_o && !supported_i |=> err_o && !busy_o);
  // R6
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !xrsp_valid_i |=> busy_o);
endmodule

// File: rtl/xlat_result_fmt.sv
module xlat_result_fmt #(
  parameter int PA_W     = 32,
  parameter int PG_SHIFT = 12,
  parameter int FS_W     = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic                   fault_i,
  input  logic [PA_W-PG_SHIFT-1:0] ppn_i,
  input  logic [PG_SHIFT-2:0]    attr_i,
  input  logic                   ext_i,
  input  logic [FS_W-1:0]        fs_i,
  output logic [PA_W-1:0]        par_o
);
  localparam int EXT_BIT = FS_W + 1;
  localparam int FSH_BIT = FS_W;

  logic [PA_W-1:0] ok_val, flt_val;

  always_comb begin
    ok_val = {ppn_i, attr_i, 1'b0};
    flt_val = '0;
    flt_val[0]             = 1'b1;
    flt_val[FS_W-1:1]      = fs_i[FS_W-2:0];
    flt_val[FSH_BIT]       = fs_i[FS_W-1];
    flt_val[EXT_BIT]       = ext_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     par_o <= '0;
    else if (load_i) par_o <= fault_i ? flt_val : ok_val;
  end

  // R7
  par_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(par_o));
  // R5
  fault_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && fault_i |=> par_o[0] && (par_o[PA_W-1:EXT_BIT+1] == '0));
  // R4
  ok_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !fault_i |=> !par_o[0]);
endmodule

// File: rtl/xlat_result_unit.sv
module xlat_result_unit #(
  parameter int OP_W     = 3,
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PG_SHIFT = 12,
  parameter int FS_W     = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      op_we_i,
  input  logic [OP_W-1:0]           op_sel_i,
  input  logic [VA_W-1:0]           op_data_i,
  output logic [PA_W-1:0]           par_o,
  output logic                      busy_o,
  output logic                      err_o,
  output logic                      overrun_o,
  output logic                      xreq_valid_o,
  input  logic                      xreq_ready_i,
  output logic [VA_W-1:0]           xreq_va_o,
  output logic [1:0]                xreq_size_o,
  output logic                      xreq_mbo_o,
  output logic                      xreq_user_o,
  output logic                      xreq_write_o,
  input  logic                      xrsp_valid_i,
  input  logic                      xrsp_fault_i,
  input  logic [PA_W-PG_SHIFT-1:0]  xrsp_ppn_i,
  input  logic [PG_SHIFT-2:0]       xrsp_attr_i,
  input  logic                      xrsp_ext_i,
  input  logic [FS_W-1:0]           xrsp_fs_i
);
  import xlat_pkg::*;

  logic       supported, rsp_take;
  xlat_mode_t dec_mode, req_mode;

  xlat_op_decode #(.OP_W(OP_W), .N_SUPP(4)) u_dec (
    .op_sel_i    (op_sel_i),
    .supported_o (supported),
    .mode_o      (dec_mode)
  );

  xlat_req_ctrl #(.VA_W(VA_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_we_i      (op_we_i),
    .supported_i  (supported),
    .mode_i       (dec_mode),
    .va_i         (op_data_i),
    .xreq_ready_i (xreq_ready_i),
    .xrsp_valid_i (xrsp_valid_i),
    .xreq_valid_o (xreq_valid_o),
    .xreq_va_o    (xreq_va_o),
    .xreq_mode_o  (req_mode),
    .busy_o       (busy_o),
    .err_o        (err_o),
    .overrun_o    (overrun_o),
    .rsp_take_o   (rsp_take)
  );

  xlat_result_fmt #(.PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .FS_W(FS_W)) u_fmt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rsp_take),
    .fault_i (xrsp_fault_i),
    .ppn_i   (xrsp_ppn_i),
    .attr_i  (xrsp_attr_i),
    .ext_i   (xrsp_ext_i),
    .fs_i    (xrsp_fs_i),
    .par_o   (par_o)
  );

  assign xreq_size_o  = 2'd0;
  assign xreq_mbo_o   = req_mode.mbo;
  assign xreq_user_o  = req_mode.user;
  assign xreq_write_o = req_mode.write;

  // R1
  req_mbo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xreq_valid_o |-> xreq_mbo_o);
endmodule

// File: tb/xlat_result_unit_test.sv
`timescale 1ns/1ps
module xlat_result_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_we = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] op_data = '0;
  logic [31:0] par;
  logic        busy, err, ovr, rq_v, rq_mbo, rq_user, rq_wr;
  logic [31:0] rq_va;
  logic [1:0]  rq_size;
  logic        rq_rdy = 1'b0, rs_v = 1'b0, rs_f = 1'b0, rs_ext = 1'b0;
  logic [19:0] rs_ppn = '0;
  logic [10:0] rs_attr = '0;
  logic [4:0]  rs_fs = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  xlat_result_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .op_we_i(op_we), .op_sel_i(op_sel), .op_data_i(op_data),
    .par_o(par), .busy_o(busy), .err_o(err), .overrun_o(ovr),
    .xreq_valid_o(rq_v), .xreq_ready_i(rq_rdy), .xreq_va_o(rq_va), .xreq_size_o(rq_size),
    .xreq_mbo_o(rq_mbo), .xreq_user_o(rq_user), .xreq_write_o(rq_wr),
    .xrsp_valid_i(rs_v), .xrsp_fault_i(rs_f), .xrsp_ppn_i(rs_ppn), .xrsp_attr_i(rs_attr),
    .xrsp_ext_i(rs_ext), .xrsp_fs_i(rs_fs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] sel, input logic [31:0] va, input int rdy_dly,
                        input int rsp_dly, input bit flt, input logic [19:0] ppn,
                        input logic [10:0] attr, input bit ext, input logic [4:0] fs,
                        input bit do_ovr);
    logic [31:0] prev, exp;
    prev = par;
    if (flt) exp = (32'(ext) << 6) | (32'(fs[4]) << 5) | (32'(fs[3:0]) << 1) | 32'd1;
    else     exp = (32'(ppn) << 12) | (32'(attr) << 1);
    @(negedge clk);
    op_we = 1'b1; op_sel = sel; op_data = va;
    @(negedge clk);
    op_we = 1'b0; op_data = ~va;
    if (sel >= 3'd4) begin
      chk("R2 err pulse", 32'(err), 32'd1);
      chk("R2 busy low", 32'(busy), 32'd0);
      chk("R2 no request", 32'(rq_v), 32'd0);
      chk("R2 par kept", par, prev);
      @(negedge clk);
      chk("R2 err single cycle", 32'(err), 32'd0);
      return;
    end
    chk("R6 busy on issue", 32'(busy), 32'd1);
    chk("R2 no err on supported", 32'(err), 32'd0);
    chk("R3 valid on issue", 32'(rq_v), 32'd1);
    chk("R1 va", rq_va, va);
    chk("R1 mbo/user/write", {29'd0, rq_mbo, rq_user, rq_wr}, {29'd0, 1'b1, sel[1], sel[0]});
    chk("R1 size one byte", 32'(rq_size), 32'd0);
    for (int i = 0; i < rdy_dly; i++) begin
      @(negedge clk);
      chk("R3 valid held", 32'(rq_v), 32'd1);
      chk("R3 va held", rq_va, va);
      chk("R7 par held in req", par, prev);
    end
    rq_rdy = 1'b1;
    @(negedge clk);
    rq_rdy = 1'b0;
    chk("R3 valid drops", 32'(rq_v), 32'd0);
    chk("R6 busy in wait", 32'(busy), 32'd1);
    if (do_ovr) begin
      op_we = 1'b1; op_sel = sel ^ 3'd3; op_data = 32'hdead_beef;
      @(negedge clk);
      op_we = 1'b0;
      chk("R8 overrun pulse", 32'(ovr), 32'd1);
      chk("R8 va unaffected", rq_va, va);
      chk("R8 no new request", 32'(rq_v), 32'd0);
      chk("R7 par held on overrun", par, prev);
    end
    for (int i = 0; i < rsp_dly; i++) begin
      @(negedge clk);
      chk("R6 busy waits", 32'(busy), 32'd1);
      chk("R7 par held in wait", par, prev);
    end
    rs_v = 1'b1; rs_f = flt; rs_ppn = ppn; rs_attr = attr; rs_ext = ext; rs_fs = fs;
    @(negedge clk);
    rs_v = 1'b0; rs_ppn = ~ppn; rs_attr = ~attr; rs_fs = ~fs; rs_ext = ~ext; rs_f = ~flt;
    chk("R6 busy clears", 32'(busy), 32'd0);
    chk(flt ? "R5 fault format" : "R4 success format", par, exp);
    chk("R8 overrun single cycle", 32'(ovr), 32'd0);
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9
    chk("R9 par reset", par, 32'd0);
    chk("R9 flags reset", {27'd0, busy, err, ovr, rq_v, 1'b0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 R4: all codes, several addresses and handshake delays
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 3; k++) begin
        run_op(3'(s), 32'h1000_0000 * (k + 1) + 32'(s * 32'h111), k, 2 - k, 1'b0,
               20'(32'h5_a000 + s * 7 + k), 11'(32'h155 ^ (s << k)), 1'b0, 5'd0, 1'b0);
      end
    end
    // R5: fault sweep over all status codes and abort bit
    for (int e = 0; e < 2; e++) begin
      for (int f = 0; f < 32; f++) begin
        run_op(3'(f % 4), 32'(f * 32'h0101_0101), f % 2, e, 1'b1, 20'hfffff, 11'h7ff,
               e[0], 5'(f), 1'b0);
      end
    end
    // R4 boundaries
    run_op(3'd0, 32'hffff_ffff, 0, 0, 1'b0, 20'hfffff, 11'h7ff, 1'b0, 5'd0, 1'b0);
    run_op(3'd3, 32'h0000_0000, 0, 0, 1'b0, 20'h00000, 11'h000, 1'b0, 5'd0, 1'b0);
    // R8: overrun in the waiting window, each code
    for (int s = 0; s < 4; s++) begin
      run_op(3'(s), 32'hcafe_0000 + 32'(s), 1, 2, s[0], 20'(s + 1), 11'(s * 3), s[1],
             5'(s + 9), 1'b1);
    end
    // R2: unsupported right after a fault result keeps the fault value
    run_op(3'd6, 32'h1234_5678, 0, 0, 1'b0, 20'd0, 11'd0, 1'b0, 5'd0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule